// File: doc/BRIEF.md
# T1 Timeslot Idle-Code and Loopback Selector

This block sits in the transmit data path of a T1 framer. It picks the serial data for each bit of the outgoing frame. A frame here is 193 bits long: one framing bit, then 24 DS0 timeslots of 8 bits each. The block receives two bit streams that share one bit clock and one frame sync. The first is backplane transmit data. The second is the output of the receive-side framer. A 24-bit per-channel select mask decides which timeslots are altered, and a single mode bit decides what the alteration is:

- With the mode bit at 0, a selected timeslot carries a programmable 8-bit idle code, sent most significant bit first.
- With the mode bit at 1, a selected timeslot is looped back bit for bit from the receive stream.
- An unselected timeslot always carries the backplane data.

The framing bit is never altered.

Alongside the data the block outputs a per-bit flag. The flag tells the later signaling stage whether robbed-bit signaling and bit-7 stuffing may be applied to the current bit. Replaced channels remain eligible. A channel is made ineligible only by its bit in a separate transparency mask input.

A small write-only register port loads the three select registers, the idle code and the mode bit into shadow copies. The shadow copies move into the working copies on the framing bit, so a frame is never altered halfway through a timeslot.

Top module: `t1_slot_sel`

## Requirements
- R1: While reset is asserted, `tx_data` and `tx_sig_ok` are 0. After reset, all select bits, the idle code and the mode bit are 0, so every bit of the frame carries the backplane data.
- R2: Frame position 0 is the framing bit. Channel n (1..24) occupies positions 8(n-1)+1 through 8n, and the bit at position 8(n-1)+1 is that channel's first bit. The select bit for channel n is bit ((n-1) mod 8) of the select register at address (n-1)/8, with addresses 0, 1 and 2.
- R3: With the mode bit at 0, a selected channel carries the idle code in place of the backplane data. The k-th bit of the timeslot (k = 0..7) is idle code bit 7-k. The same code is used for every selected channel.
- R4: An unselected channel carries the backplane data unchanged, in either mode.
- R5: With the mode bit at 1, a selected channel carries the receive-stream data, taken from the same bit position.
- R6: The framing bit always carries the backplane data, and `tx_sig_ok` is 0 for it.
- R7: For every channel bit, `tx_sig_ok` is the inverse of that channel's `transp` bit, whether the channel is passed through, idle-filled or looped back.
- R8: A write is captured at address 3 (idle code), address 4 (mode, data bit 0) or addresses 0 to 2 (select registers). It takes effect from the first channel bit after the next framing bit, so the frame that is running when the write happens is not affected. Writes to addresses 5 to 7 change nothing.
- R9: Each output bit appears exactly one clock after the input bit it is based on, whichever of the three sources is used.
- R10: A cycle with `fsync` high is taken as the framing bit, at any point in the frame. Without `fsync`, the position counter runs on and wraps to the framing bit after 193 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both streams |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | High during the framing-bit cycle |
| bp_data | input | 1 | Backplane transmit serial data |
| rx_data | input | 1 | Receive-side framer serial data |
| transp | input | 24 | Per-channel transparency mask, bit n-1 for channel n |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tx_data | output | 1 | Selected serial transmit data |
| tx_sig_ok | output | 1 | Signaling and bit-7 stuffing allowed on this bit |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a frame. It must leave the rest of that frame untouched and then take effect on exactly the first channel bit after the framing bit. The bench continues streaming random data on both inputs while it writes. It writes the select registers at about position 100, and the mode and idle code in the middle of a timeslot. It compares every output bit against a model that keeps its own shadow and working copies.

A second scenario moves `fsync` to an unexpected position partway through a frame. It then withholds `fsync` for whole frames, so the bench can check both the resynchronisation and the free-running wrap.

// File: rtl/t1sel_pkg.sv
package t1sel_pkg;
   // Source chosen for one outgoing bit
   typedef enum logic [1:0] {
      SRC_BACKPLANE = 2'd0,
      SRC_IDLE      = 2'd1,
      SRC_RECEIVE   = 2'd2
   } t1sel_src_e;

   // Frame position broken into its parts
   typedef struct packed {
      logic       fbit;
      logic [4:0] slot;
      logic [2:0] bitn;
   } t1sel_pos_t;

   function automatic bit t1sel_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/t1sel_slot_ctr.sv
module t1sel_slot_ctr #(
   parameter int unsigned SLOTS     = 24,
   parameter int unsigned SLOT_BITS = 8,
   localparam int unsigned CH_W     = $clog2(SLOTS),
   localparam int unsigned BIT_W    = $clog2(SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   output logic             cur_fbit,
   output logic [CH_W-1:0]  cur_slot,
   output logic [BIT_W-1:0] cur_bit
);
   localparam logic [CH_W-1:0]  LAST_SLOT = CH_W'(SLOTS - 1);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_BITS - 1);

   logic             fbit_q,  fbit_d;
   logic [CH_W-1:0]  slot_q,  slot_d;
   logic [BIT_W-1:0] bit_q,   bit_d;

   // A sync pulse overrides the stored position at any point
   assign cur_fbit = fsync | fbit_q;
   assign cur_slot = cur_fbit ? '0 : slot_q;
   assign cur_bit  = cur_fbit ? '0 : bit_q;

   always_comb begin
      fbit_d = 1'b0;
      slot_d = slot_q;
      bit_d  = bit_q;
      if (cur_fbit) begin
         slot_d = '0;
         bit_d  = '0;
      end else if (bit_q == LAST_BIT) begin
         bit_d = '0;
         if (slot_q == LAST_SLOT) begin
            fbit_d = 1'b1;
            slot_d = '0;
         end else begin
            slot_d = slot_q + 1'b1;
         end
      end else begin
         bit_d = bit_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fbit_q <= 1'b1;
         slot_q <= '0;
         bit_q  <= '0;
      end else begin
         fbit_q <= fbit_d;
         slot_q <= slot_d;
         bit_q  <= bit_d;
      end
   end
endmodule

// File: rtl/t1sel_cfg.sv
module t1sel_cfg #(
   parameter int unsigned SLOTS     = 24,
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned ADDR_W    = 3,
   localparam int unsigned NUM_SEL  = SLOTS / REG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [REG_W-1:0]     cfg_wdata,
   input  logic                 load,
   output logic [SLOTS-1:0]     act_sel,
   output logic [SLOT_BITS-1:0] act_idle,
   output logic                 act_mode
);
   localparam logic [ADDR_W-1:0] ADDR_IDLE = ADDR_W'(NUM_SEL);
   localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(NUM_SEL + 1);

   logic [SLOTS-1:0]     sh_sel;
   logic [SLOT_BITS-1:0] sh_idle;
   logic                 sh_mode;

   // One shadow byte per select register
   for (genvar g = 0; g < NUM_SEL; g++) begin : g_selreg
      logic hit;
      assign hit = cfg_we && (cfg_addr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sh_sel[g*REG_W +: REG_W] <= '0;
         else if (hit) sh_sel[g*REG_W +: REG_W] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_idle <= '0;
         sh_mode <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_addr == ADDR_IDLE) sh_idle <= cfg_wdata[SLOT_BITS-1:0];
         if (cfg_addr == ADDR_MODE) sh_mode <= cfg_wdata[0];
      end
   end

   // Working copies move only on the framing bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel  <= '0;
         act_idle <= '0;
         act_mode <= 1'b0;
      end else if (load) begin
         act_sel  <= sh_sel;
         act_idle <= sh_idle;
         act_mode <= sh_mode;
      end
   end
endmodule

// File: rtl/t1sel_bit_mux.sv
module t1sel_bit_mux
   import t1sel_pkg::*;
#(
   parameter int unsigned SLOTS     = 24,
   parameter int unsigned SLOT_BITS = 8,
   localparam int unsigned CH_W     = $clog2(SLOTS),
   localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
   localparam int unsigned PAD      = 1 << CH_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cur_fbit,
   input  logic [CH_W-1:0]      cur_slot,
   input  logic [BIT_W-1:0]     cur_bit,
   input  logic                 bp_bit,
   input  logic                 rx_bit,
   input  logic [SLOTS-1:0]     act_sel,
   input  logic [SLOT_BITS-1:0] act_idle,
   input  logic                 act_mode,
   input  logic [SLOTS-1:0]     transp,
   output logic                 tx_bit,
   output logic                 sig_ok
);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

   logic [PAD-1:0]   sel_pad, tr_pad;
   logic [BIT_W-1:0] idle_idx;
   t1sel_src_e       src;
   logic             bit_d, sig_d;

   assign sel_pad  = PAD'(act_sel);
   assign tr_pad   = PAD'(transp);
   assign idle_idx = LAST_BIT - cur_bit;   // MSB leaves first

   always_comb begin
      if (cur_fbit || !sel_pad[cur_slot]) src = SRC_BACKPLANE;
      else if (act_mode)                  src = SRC_RECEIVE;
      else                                src = SRC_IDLE;
   end

   always_comb begin
      unique case (src)
         SRC_IDLE:    bit_d = act_idle[idle_idx];
         SRC_RECEIVE: bit_d = rx_bit;
         default:     bit_d = bp_bit;
      endcase
      sig_d = !cur_fbit && !tr_pad[cur_slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_bit <= 1'b0;
         sig_ok <= 1'b0;
      end else begin
         tx_bit <= bit_d;
         sig_ok <= sig_d;
      end
   end
endmodule

// File: rtl/t1_slot_sel.sv
module t1_slot_sel
   import t1sel_pkg::*;
#(
   parameter int unsigned SLOTS     = 24,
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync,
   input  logic               bp_data,
   input  logic               rx_data,
   input  logic [SLOTS-1:0]   transp,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic               tx_data,
   output logic               tx_sig_ok
);
   localparam int unsigned CH_W    = $clog2(SLOTS);
   localparam int unsigned BIT_W   = $clog2(SLOT_BITS);
   localparam int unsigned NUM_SEL = SLOTS / REG_W;

   // Elaboration-time parameter checks
   if (SLOTS % REG_W != 0) begin : g_err_regs
      $error("SLOTS must fill whole select registers");
   end
   if (!t1sel_is_pow2(SLOT_BITS) || SLOT_BITS < 2) begin : g_err_bits
      $error("SLOT_BITS must be a power of two");
   end
   if (SLOT_BITS > REG_W) begin : g_err_idle
      $error("idle code must fit one register");
   end
   if (NUM_SEL + 2 > (1 << ADDR_W)) begin : g_err_addr
      $error("address space too small");
   end

   logic                 cur_fbit;
   logic [CH_W-1:0]      cur_slot;
   logic [BIT_W-1:0]     cur_bit;
   logic [SLOTS-1:0]     act_sel;
   logic [SLOT_BITS-1:0] act_idle;
   logic                 act_mode;

   t1sel_slot_ctr #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync    (fsync),
      .cur_fbit (cur_fbit),
      .cur_slot (cur_slot),
      .cur_bit  (cur_bit)
   );

   t1sel_cfg #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .REG_W(REG_W),
               .ADDR_W(ADDR_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .load      (cur_fbit),
      .act_sel   (act_sel),
      .act_idle  (act_idle),
      .act_mode  (act_mode)
   );

   t1sel_bit_mux #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_fbit (cur_fbit),
      .cur_slot (cur_slot),
      .cur_bit  (cur_bit),
      .bp_bit   (bp_data),
      .rx_bit   (rx_data),
      .act_sel  (act_sel),
      .act_idle (act_idle),
      .act_mode (act_mode),
      .transp   (transp),
      .tx_bit   (tx_data),
      .sig_ok   (tx_sig_ok)
   );
endmodule

// File: rtl/t1sel_chk.sv
module t1sel_chk #(
   parameter int unsigned SLOTS     = 24,
   parameter int unsigned SLOT_BITS = 8,
   localparam int unsigned CH_W     = $clog2(SLOTS),
   localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
   localparam int unsigned PAD      = 1 << CH_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bp_data,
   input logic                 rx_data,
   input logic [SLOTS-1:0]     transp,
   input logic                 tx_data,
   input logic                 tx_sig_ok,
   input logic                 cur_fbit,
   input logic [CH_W-1:0]      cur_slot,
   input logic [BIT_W-1:0]     cur_bit,
   input logic [SLOTS-1:0]     act_sel,
   input logic [SLOT_BITS-1:0] act_idle,
   input logic                 act_mode
);
   logic [PAD-1:0]   sel_p, tr_p;
   logic [BIT_W-1:0] iidx;
   assign sel_p = PAD'(act_sel);
   assign tr_p  = PAD'(transp);
   assign iidx  = BIT_W'(SLOT_BITS - 1) - cur_bit;

   AST_FBIT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      cur_fbit |=> tx_data == $past(bp_data)); // R6
   AST_FBIT_NOSIG: assert property (@(posedge clk) disable iff (!rst_n)
      cur_fbit |=> !tx_sig_ok); // R6
   AST_UNSEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cur_fbit && !sel_p[cur_slot]) |=> tx_data == $past(bp_data)); // R4
   AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cur_fbit && sel_p[cur_slot] && !act_mode) |=> tx_data == $past(act_idle[iidx])); // R3
   AST_LOOP_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (!cur_fbit && sel_p[cur_slot] && act_mode) |=> tx_data == $past(rx_data)); // R5
   AST_SIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_fbit |=> tx_sig_ok == !$past(tr_p[cur_slot])); // R7
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_fbit |=> ($stable(act_sel) && $stable(act_idle) && $stable(act_mode))); // R8
endmodule

bind t1_slot_sel t1sel_chk #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bp_data   (bp_data),
   .rx_data   (rx_data),
   .transp    (transp),
   .tx_data   (tx_data),
   .tx_sig_ok (tx_sig_ok),
   .cur_fbit  (cur_fbit),
   .cur_slot  (cur_slot),
   .cur_bit   (cur_bit),
   .act_sel   (act_sel),
   .act_idle  (act_idle),
   .act_mode  (act_mode)
);

// File: tb/t1_slot_sel_bench.sv
module t1_slot_sel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0;
   logic        bp_data = 1'b0;
   logic        rx_data = 1'b0;
   logic [23:0] transp = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        tx_data, tx_sig_ok;

   always #2.5 clk = ~clk;   // 200 MHz

   t1_slot_sel u_t1_slot_sel (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .bp_data(bp_data),
      .rx_data(rx_data), .transp(transp), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .tx_data(tx_data), .tx_sig_ok(tx_sig_ok)
   );

   int n_chk = 0, n_bad = 0;
   string ctx = "R1";

   // bench model
   int          cnt = 0;
   bit          fs_en = 1, force_fs = 0;
   logic [23:0] sh_sel = '0, ac_sel = '0;
   logic [7:0]  sh_idle = '0, ac_idle = '0;
   logic        sh_mode = 0, ac_mode = 0;
   logic        exp_d, exp_s;
   string       exp_req;
   bit          exp_valid = 0;

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s) t=%0t actual=%b expected=%b", req, ctx, $time, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // one bit period, entered and left at a falling edge
   task automatic step();
      bit fs;
      int pos, ch, bi;
      if (exp_valid) begin
         check(tx_data, exp_d, exp_req);            // R9: one-clock latency
         check(tx_sig_ok, exp_s, (exp_req == "R6") ? "R6" : "R7");
      end
      fs = (fs_en && cnt == 0) || force_fs;
      force_fs = 0;
      pos = fs ? 0 : cnt;
      fsync = fs;
      bp_data = 1'($urandom);
      rx_data = 1'($urandom);
      if (pos == 0) begin
         exp_d = bp_data; exp_s = 1'b0; exp_req = "R6";
         ac_sel = sh_sel; ac_idle = sh_idle; ac_mode = sh_mode;
      end else begin
         ch = (pos - 1) / 8;
         bi = (pos - 1) % 8;
         exp_s = !transp[ch];
         if (!ac_sel[ch]) begin exp_d = bp_data; exp_req = "R4"; end
         else if (ac_mode) begin exp_d = rx_data; exp_req = "R5"; end
         else begin exp_d = ac_idle[7 - bi]; exp_req = "R3"; end
      end
      if (cfg_we) begin
         if (cfg_addr < 3) for (int b = 0; b < 8; b++) sh_sel[cfg_addr*8 + b] = cfg_wdata[b];
         else if (cfg_addr == 3) sh_idle = cfg_wdata;
         else if (cfg_addr == 4) sh_mode = cfg_wdata[0];
      end
      cnt = (pos == 192) ? 0 : pos + 1;
      exp_valid = 1;
      @(negedge clk);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic run_to(input int p);   // stop with cnt == p
      while (cnt != p) step();
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      step();
      cfg_we = 0;
   endtask

   task automatic t_reset();
      ctx = "R1";
      rst_n = 0;
      for (int i = 0; i < 4; i++) begin
         bp_data = 1'($urandom); fsync = 1'($urandom);
         @(negedge clk);
         check(tx_data, 1'b0, "R1");
         check(tx_sig_ok, 1'b0, "R1");
      end
      fsync = 0;
      rst_n = 1;
      run(2 * 193);   // all zero config: pass-through, R1
   endtask

   task automatic t_mapping();
      ctx = "R2";
      run_to(10);
      cfg_write(3, 8'hA5);
      cfg_write(0, 8'h01);   // ch1
      cfg_write(1, 8'h08);   // ch12
      cfg_write(2, 8'h80);   // ch24
      transp = 24'h000800;   // ch12 transparent
      run(2 * 193);
   endtask

   task automatic t_idle_pattern();
      ctx = "R3";
      run_to(20);
      cfg_write(3, 8'h3C);
      cfg_write(0, 8'hF0);
      cfg_write(1, 8'h5A);
      cfg_write(2, 8'hFF);
      transp = 24'h81_0002;
      run(2 * 193);
   endtask

   task automatic t_loopback();
      ctx = "R5";
      run_to(30);
      cfg_write(4, 8'h01);
      cfg_write(0, 8'hC3);
      cfg_write(1, 8'h00);
      cfg_write(2, 8'h81);
      transp = 24'h00_1F00;
      run(2 * 193);
   endtask

   task automatic t_midframe();
      ctx = "R8";
      run_to(100);
      cfg_write(0, 8'hFF);
      cfg_write(1, 8'hFF);
      cfg_write(2, 8'hFF);
      run_to(44);            // middle of ch6
      cfg_write(4, 8'h00);
      cfg_write(3, 8'h96);
      cfg_write(5, 8'h00);   // unmapped addresses: no effect
      cfg_write(6, 8'hFF);
      cfg_write(7, 8'h55);
      run(2 * 193);
      run_to(0);
      cfg_write(4, 8'h01);   // write on the framing bit: waits one more frame
      run(2 * 193);
   endtask

   task automatic t_freerun();
      ctx = "R10";
      transp = 24'h0;
      run_to(60);
      force_fs = 1;          // early sync restarts the frame
      step();
      fs_en = 0;
      run(3 * 193);
      fs_en = 1;
      run(193);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_mapping();
      t_idle_pattern();
      t_loopback();
      t_midframe();
      t_freerun();
      summary();
   end
endmodule